// File: doc/BRIEF.md
# Selective Register Reset Controller for a USB 2.0 Host Controller

This block decides which groups of registers in a USB 2.0 host controller are cleared when a reset event occurs. Each register carries a class tag, fixed at build time. Three events can clear registers. The chip's hardware reset clears every class. A software-set host-controller reset bit clears only the registers that the host-controller driver owns. A software write that takes the device power-state field from the low-power hot state back to fully-on clears the core-well registers. It spares the wake-related suspend-well state and the registers that firmware programmed at boot.

The block outputs one clear strobe per register. Each register's own logic zeroes its contents on that strobe. Two per-register exception masks let the integrator exempt individual registers from either software event. The host-controller reset bit and the power-state field are held here, and their values are returned for readback.

Class tags are 3 bits per register, packed with register i at bits [3i+2:3i]:

| Tag | Register class |
|---|---|
| 0 | operational memory-space |
| 1 | structural parameters written by firmware |
| 2 | configuration space |
| 3 | core-well |
| 4 | firmware-programmed core-well |
| 5 | suspend-well |

Top module: `usb_hc_reset_ctl`

## Requirements
- R1: A cycle with `hc_rst_wr` high, while the reset bit reads 0, sets `hc_rst_bit` to 1 at the next clock edge. One edge later the controller's clear strobe goes high for exactly one cycle. At the edge after that, `hc_rst_bit` returns to 0.
- R2: The controller's clear strobe drives `reg_clr[i]` high for every register whose tag is 0 (operational) and that is not exempted by `hc_excl[i]`.
- R3: The controller's clear strobe never drives `reg_clr` for registers tagged 1, 2, 3, 4 or 5.
- R4: Suppose the current power state is 2'b11 and a cycle has `pm_wr` high with `pm_wdata` = 2'b00. After the next clock edge, `reg_clr[i]` is high for exactly one cycle for every register tagged 0 or 3 that is not exempted by `pm_excl[i]`.
- R5: The power-state transition never drives `reg_clr` for registers tagged 1, 2, 4 or 5.
- R6: No other power-state write produces a clear strobe. This covers any other value pair and writes that repeat the current state. `pm_state` takes the written value at the clock edge after each write.
- R7: A register with its `hc_excl` bit set is not cleared by the controller reset bit. A register with its `pm_excl` bit set is not cleared by the power-state transition.
- R8: A `hc_rst_wr` that arrives while `hc_rst_bit` reads 1 is ignored: a held write yields only one strobe.
- R9: While `rst` is high, every `reg_clr` bit is 1 whatever the masks and software inputs. After a reset, `hc_rst_bit` reads 0 and `pm_state` reads 2'b00.
- R10: When both software strobes fall in the same cycle, `reg_clr` is the union of the two clear sets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | core clock |
| rst | input | 1 | synchronous active-high hardware reset |
| hc_rst_wr | input | 1 | software writes 1 to the host-controller reset bit |
| pm_wr | input | 1 | software write strobe for the power-state field |
| pm_wdata | input | 2 | power-state value being written |
| hc_excl | input | NUM_REGS | exempts a register from the controller reset bit |
| pm_excl | input | NUM_REGS | exempts a register from the power-state transition |
| reg_clr | output | NUM_REGS | per-register clear strobe |
| hc_rst_bit | output | 1 | readback of the host-controller reset bit |
| pm_state | output | 2 | readback of the power-state field |

## Verification
On every cycle, the assertions check four things:
- the one-cycle width and the self-clearing of the controller strobe;
- that a power strobe only follows a write of 2'b00 over 2'b11;
- that a write of any other value leaves the power strobe low;
- that the protected classes are never cleared outside hardware reset.

Some behaviour only the bench scenarios can show. These are:
- the exact composition of each clear set and how the exception masks carve into it;
- the union when both strobes coincide;
- that a held write produces a single strobe;
- that hardware reset overrides the masks.

// File: rtl/usb_hc_reset_pkg.sv
package usb_hc_reset_pkg;

    localparam int TAG_W = 3;

    typedef enum logic [TAG_W-1:0] {
        TAG_OPER    = 3'd0,
        TAG_STRUCT  = 3'd1,
        TAG_CFG     = 3'd2,
        TAG_CORE    = 3'd3,
        TAG_CORE_FW = 3'd4,
        TAG_SUSP    = 3'd5
    } reg_tag_e;

    localparam logic [1:0] PS_ON  = 2'b00;
    localparam logic [1:0] PS_HOT = 2'b11;

    typedef struct packed {
        logic hw;
        logic hc;
        logic pm;
    } clr_evt_t;

    typedef enum logic [1:0] {
        HCR_IDLE  = 2'd0,
        HCR_ARMED = 2'd1,
        HCR_FIRE  = 2'd2
    } hcr_state_e;

    // Controller reset bit: driver-owned memory-space registers only.
    function automatic logic hc_clears(input logic [TAG_W-1:0] tag);
        return tag == TAG_OPER;
    endfunction

    // Hot-to-on transition: core well, sparing firmware and wake state.
    function automatic logic pm_clears(input logic [TAG_W-1:0] tag);
        return (tag == TAG_OPER) || (tag == TAG_CORE);
    endfunction

endpackage

// File: rtl/usb_hc_rst_seq.sv
module usb_hc_rst_seq
    import usb_hc_reset_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic wr,
    output logic busy,
    output logic strobe
);

    hcr_state_e st_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= HCR_IDLE;
        end else begin
            unique case (st_q)
                HCR_IDLE:  if (wr) st_q <= HCR_ARMED;
                HCR_ARMED: st_q <= HCR_FIRE;
                default:   st_q <= HCR_IDLE;
            endcase
        end
    end

    assign busy   = (st_q != HCR_IDLE);
    assign strobe = (st_q == HCR_FIRE);

    AST_HCR_ONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        strobe |=> !strobe);                                              // R1
    AST_HCR_SELF_CLEAR: assert property (@(posedge clk) disable iff (rst)
        strobe |=> !busy);                                                // R1
    AST_HCR_ARMED_FIRST: assert property (@(posedge clk) disable iff (rst)
        $rose(strobe) |-> $past(busy));                                   // R1
    AST_HCR_BUSY_IGNORES: assert property (@(posedge clk) disable iff (rst)
        (busy && !strobe) |=> strobe);                                    // R8

endmodule

// File: rtl/usb_hc_pm_detect.sv
module usb_hc_pm_detect
    import usb_hc_reset_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr,
    input  logic [1:0] wdata,
    output logic [1:0] state,
    output logic       pulse
);

    logic [1:0] state_q;
    logic       pulse_q;
    logic       wake_hit;

    assign wake_hit = wr && (state_q == PS_HOT) && (wdata == PS_ON);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PS_ON;
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= wake_hit;
            if (wr) state_q <= wdata;
        end
    end

    assign state = state_q;
    assign pulse = pulse_q;

    AST_PM_FROM_HOT: assert property (@(posedge clk) disable iff (rst)
        pulse |-> ($past(state) == PS_HOT) && (state == PS_ON));         // R4
    AST_PM_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !($past(wr) && $past(state) == PS_HOT && $past(wdata) == PS_ON))
        |-> !pulse);                                                      // R6

endmodule

// File: rtl/usb_hc_clr_matrix.sv
module usb_hc_clr_matrix
    import usb_hc_reset_pkg::*;
#(
    parameter int NUM_REGS = 12,
    parameter logic [NUM_REGS*TAG_W-1:0] REG_TAGS = '0
) (
    input  logic                clk,
    input  logic                rst,
    input  clr_evt_t            evt,
    input  logic [NUM_REGS-1:0] hc_excl,
    input  logic [NUM_REGS-1:0] pm_excl,
    output logic [NUM_REGS-1:0] clr
);

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        localparam logic [TAG_W-1:0] TAG = REG_TAGS[i*TAG_W +: TAG_W];
        localparam bit HIT_HC = hc_clears(TAG);
        localparam bit HIT_PM = pm_clears(TAG);

        assign clr[i] = evt.hw
                      | (HIT_HC & evt.hc & ~hc_excl[i])
                      | (HIT_PM & evt.pm & ~pm_excl[i]);

        if (!HIT_HC && !HIT_PM) begin : g_keep
            AST_KEEP_PROTECTED: assert property (@(posedge clk) disable iff (rst)
                !clr[i]);                                                 // R3, R5
        end

        AST_EXCL_HONOURED: assert property (@(posedge clk) disable iff (rst)
            (hc_excl[i] && pm_excl[i]) |-> !clr[i]);                      // R7
    end

endmodule

// File: rtl/usb_hc_reset_ctl.sv
module usb_hc_reset_ctl
    import usb_hc_reset_pkg::*;
#(
    parameter int NUM_REGS = 12,
    parameter logic [NUM_REGS*TAG_W-1:0] REG_TAGS = {
        3'd5, 3'd5, 3'd4, 3'd4, 3'd3, 3'd3,
        3'd2, 3'd2, 3'd1, 3'd1, 3'd0, 3'd0}
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                hc_rst_wr,
    input  logic                pm_wr,
    input  logic [1:0]          pm_wdata,
    input  logic [NUM_REGS-1:0] hc_excl,
    input  logic [NUM_REGS-1:0] pm_excl,
    output logic [NUM_REGS-1:0] reg_clr,
    output logic                hc_rst_bit,
    output logic [1:0]          pm_state
);

    logic     hc_strobe;
    logic     pm_pulse;
    clr_evt_t evt;

    usb_hc_rst_seq i_seq (
        .clk    (clk),
        .rst    (rst),
        .wr     (hc_rst_wr),
        .busy   (hc_rst_bit),
        .strobe (hc_strobe)
    );

    usb_hc_pm_detect i_pm (
        .clk   (clk),
        .rst   (rst),
        .wr    (pm_wr),
        .wdata (pm_wdata),
        .state (pm_state),
        .pulse (pm_pulse)
    );

    always_comb begin
        evt.hw = rst;
        evt.hc = hc_strobe;
        evt.pm = pm_pulse;
    end

    usb_hc_clr_matrix #(
        .NUM_REGS (NUM_REGS),
        .REG_TAGS (REG_TAGS)
    ) i_matrix (
        .clk     (clk),
        .rst     (rst),
        .evt     (evt),
        .hc_excl (hc_excl),
        .pm_excl (pm_excl),
        .clr     (reg_clr)
    );

    AST_HW_AFTER_STATE: assert property (@(posedge clk)
        $past(rst) |-> (!hc_rst_bit && pm_state == PS_ON));               // R9

endmodule

// File: tb/test_usb_hc_reset_ctl.sv
module test_usb_hc_reset_ctl;

    localparam int CLK_PERIOD = 10;
    localparam int N = 12;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         hc_rst_wr = 1'b0;
    logic         pm_wr = 1'b0;
    logic [1:0]   pm_wdata = 2'b00;
    logic [N-1:0] hc_excl = '0;
    logic [N-1:0] pm_excl = '0;
    logic [N-1:0] reg_clr;
    logic         hc_rst_bit;
    logic [1:0]   pm_state;

    int total = 0;
    int bad = 0;
    bit started = 0;

    // behavioural reference state
    int m_stage = 0;
    int m_ps = 0;
    bit m_pm = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    usb_hc_reset_ctl i_usb_hc_reset_ctl (
        .clk(clk), .rst(rst), .hc_rst_wr(hc_rst_wr), .pm_wr(pm_wr),
        .pm_wdata(pm_wdata), .hc_excl(hc_excl), .pm_excl(pm_excl),
        .reg_clr(reg_clr), .hc_rst_bit(hc_rst_bit), .pm_state(pm_state)
    );

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    // tags by index: reg i has class i/2 (0 oper,1 struct,2 cfg,3 core,4 core fw,5 susp)
    function automatic logic [N-1:0] model_clr();
        logic [N-1:0] v;
        for (int i = 0; i < N; i++) begin
            int c = i / 2;
            v[i] = rst
                 || (m_stage == 2 && c == 0 && !hc_excl[i])
                 || (m_pm && (c == 0 || c == 3) && !pm_excl[i]);
        end
        return v;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_stage = 0; m_ps = 0; m_pm = 0;
        end else begin
            m_pm = pm_wr && m_ps == 3 && pm_wdata == 2'b00;
            if (pm_wr) m_ps = int'(pm_wdata);
            case (m_stage)
                0: if (hc_rst_wr) m_stage = 1;
                1: m_stage = 2;
                default: m_stage = 0;
            endcase
        end
        started = 1;
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (started) begin
            logic [N-1:0] e;
            string tg;
            e = model_clr();
            if (rst) tg = "R9";
            else if (m_stage == 2 && m_pm) tg = "R10";
            else if (m_stage == 2) tg = "R2";
            else if (m_pm) tg = "R4";
            else tg = "R6";
            chk(reg_clr == e, tg, 32'(reg_clr), 32'(e));
            chk(hc_rst_bit == (m_stage != 0), "R1", 32'(hc_rst_bit), 32'(m_stage != 0));
            chk(int'(pm_state) == m_ps, "R6", 32'(pm_state), 32'(m_ps));
        end
    end

    task automatic step(input int n = 1);
        repeat (n) begin
            @(posedge clk);
            #2;
        end
    endtask

    task automatic pm_write(input logic [1:0] v);
        pm_wr = 1'b1; pm_wdata = v;
        step();
        pm_wr = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int pulses;
        step(3);
        @(negedge clk); #1;
        chk(reg_clr == '1, "R9", 32'(reg_clr), 32'hfff);
        step();
        rst = 1'b0;
        step(2);
        chk(hc_rst_bit == 1'b0 && pm_state == 2'b00, "R9",
            {30'd0, hc_rst_bit, 1'b0}, 32'd0);

        // controller reset bit: R1, R2, R3
        hc_rst_wr = 1'b1; step(); hc_rst_wr = 1'b0;
        chk(hc_rst_bit == 1'b1, "R1", 32'(hc_rst_bit), 32'd1);
        step();
        chk(reg_clr == 12'h003, "R2 R3", 32'(reg_clr), 32'h003);
        step();
        chk(hc_rst_bit == 1'b0 && reg_clr == '0, "R1", 32'(reg_clr), 32'd0);

        // held write while busy: R8
        pulses = 0;
        hc_rst_wr = 1'b1;
        for (int k = 0; k < 3; k++) begin
            step();
            if (reg_clr[0]) pulses++;
        end
        hc_rst_wr = 1'b0;
        for (int k = 0; k < 4; k++) begin
            step();
            if (reg_clr[0]) pulses++;
        end
        chk(pulses == 1, "R8", 32'(pulses), 32'd1);

        // power-state writes without the hot-to-on transition: R6
        pm_write(2'b11); chk(reg_clr == '0, "R6", 32'(reg_clr), 32'd0);
        pm_write(2'b11); chk(reg_clr == '0, "R6", 32'(reg_clr), 32'd0);
        pm_write(2'b01); chk(reg_clr == '0, "R6", 32'(reg_clr), 32'd0);
        pm_write(2'b00); chk(reg_clr == '0, "R6", 32'(reg_clr), 32'd0);
        pm_write(2'b00); chk(reg_clr == '0, "R6", 32'(reg_clr), 32'd0);
        pm_write(2'b11);
        pm_write(2'b10); chk(reg_clr == '0 && pm_state == 2'b10, "R6", 32'(reg_clr), 32'd0);

        // hot to on: R4, R5
        pm_write(2'b11);
        pm_write(2'b00);
        chk(reg_clr == 12'h0c3, "R4 R5", 32'(reg_clr), 32'h0c3);
        step();
        chk(reg_clr == '0, "R4", 32'(reg_clr), 32'd0);

        // exception masks: R7
        hc_excl = 12'h001; pm_excl = 12'h041;
        hc_rst_wr = 1'b1; step(); hc_rst_wr = 1'b0; step();
        chk(reg_clr == 12'h002, "R7", 32'(reg_clr), 32'h002);
        step(2);
        pm_write(2'b11); pm_write(2'b00);
        chk(reg_clr == 12'h082, "R7", 32'(reg_clr), 32'h082);
        hc_excl = '0; pm_excl = '0;
        step(2);

        // coincident strobes: R10
        pm_write(2'b11);
        hc_rst_wr = 1'b1; step(); hc_rst_wr = 1'b0;
        pm_write(2'b00);
        chk(reg_clr == 12'h0c3, "R10", 32'(reg_clr), 32'h0c3);
        hc_excl = 12'h003; pm_excl = 12'h040;
        step(2);
        pm_write(2'b11);
        hc_rst_wr = 1'b1; step(); hc_rst_wr = 1'b0;
        pm_write(2'b00);
        chk(reg_clr == 12'h083, "R10", 32'(reg_clr), 32'h083);
        step(2);

        // hardware reset over masks and pending work: R9
        hc_excl = '1; pm_excl = '1;
        pm_write(2'b11);
        hc_rst_wr = 1'b1; step(); hc_rst_wr = 1'b0;
        rst = 1'b1;
        @(negedge clk); #1;
        chk(reg_clr == '1, "R9", 32'(reg_clr), 32'hfff);
        step(2);
        rst = 1'b0;
        step();
        chk(hc_rst_bit == 1'b0 && pm_state == 2'b00 && reg_clr == '0, "R9",
            32'(pm_state), 32'd0);
        hc_excl = '0; pm_excl = '0;
        step(3);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule